// File: doc/BRIEF.md
# Dual-Source Master Clock Switch

This block chooses which clock drives the internal master clock of a digital core. One candidate is a free-running on-chip oscillator. The other is an external serial bit clock. After reset the core always runs from the oscillator. Software then moves the core between the two sources by changing a single presence flag.

When the flag differs from the source in use, the block waits for the control bus to go quiet. That means either no transaction is open, or the open one has just ended with its stop condition. The block then hands the clock over through a cross-coupled, falling-edge-synchronised gate pair, so no short pulse can appear on the output clock. From the moment of that decision it raises a hold-off flag for a fixed time. The length is given in microseconds and converted to oscillator cycles. The bus engine must accept no new transaction while the flag is high.

A two-bit status code, updated on the output clock itself, reports the state: oscillator, in transition, or external. A separate bit tells the analog side that the oscillator may be powered down.

Top module: `mclk_switch`

## Requirements
- R1: While `rst` is high and after it falls, the output clock runs from `osc_clk`, `hold_busy` is 0, `src_stat` is 2'b00 and `osc_pd` is 0.
- R2: After two `osc_clk` synchroniser stages, if `ext_present` differs from the selected source (1 = external), a switch is pending. A 0-to-1 change moves toward `ext_clk`, and a 1-to-0 change moves back to `osc_clk`. The selection changes only on the edge that starts a switch.
- R3: A pending switch starts on an `osc_clk` edge where `bus_active` is 0 or `bus_stop` is 1. While `bus_active` is 1 without `bus_stop`, nothing starts. A `bus_stop` with no pending switch has no effect.
- R4: `hold_busy` rises on the edge that starts a switch and stays high for exactly HOLD_CYC = ceil(OSC_FREQ_HZ × HOLD_US / 10^6) `osc_clk` cycles.
- R5: Each source has a gate enable that passes through SYNC_STAGES flops clocked on that source's falling edge. A source is enabled only after the other source's enable is low, so both enables are never high together.
- R6: `src_stat` encodes 2'b00 = oscillator, 2'b01 = in transition, 2'b11 = external. It never takes 2'b10 and changes at most one bit per update. It is registered on `mclk`, the currently selected clock.
- R7: While `hold_busy` is high and the handover has settled, `src_stat` reads 2'b01.
- R8: `osc_pd` goes high only once the external gate is enabled, the flag is still 1 and the hold-off has ended. It clears within a few `ext_clk` cycles of the flag falling, before the oscillator gate is re-enabled.
- R9: A flag change that arrives during a switch or its hold-off is not lost. It starts the next switch, at the earliest, one cycle after `hold_busy` falls. The selection stays stable while `hold_busy` is high.
- R10: Once a switch and its hold-off have settled, `mclk` has the period of the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running on-chip oscillator clock; clocks the request logic |
| ext_clk | input | 1 | External serial bit clock; running throughout any switch |
| rst | input | 1 | Synchronous active-high reset |
| ext_present | input | 1 | Software presence flag: 1 requests the external source |
| bus_active | input | 1 | A control-bus transaction is open (oscillator domain) |
| bus_stop | input | 1 | One-cycle pulse at a control-bus stop condition (oscillator domain) |
| mclk | output | 1 | Glitch-free internal master clock |
| hold_busy | output | 1 | Bus hold-off: no new transaction may start while high |
| src_stat | output | 2 | Source status code, one-bit steps |
| osc_pd | output | 1 | Oscillator may be powered down |

## Verification
A wrong request or timer state shows up on `hold_busy` at once. A busy pulse that starts one cycle early or late, is one cycle too long, or appears while a transaction is open differs from the behavioural model on the next oscillator edge. A handover left half-done shows within a few tens of cycles after the hold-off. It appears as a stale `src_stat`, a wrong `osc_pd`, or an `mclk` period that does not match the selected source. A queued flag change that is lost shows as a missing second busy pulse right after the first one ends.

// File: rtl/mclk_sw_pkg.sv
`timescale 1ns/1ps
package mclk_sw_pkg;

  // Source status code: single-bit steps 00 <-> 01 <-> 11
  typedef enum logic [1:0] {
    SRC_OSC    = 2'b00,
    SRC_MOVING = 2'b01,
    SRC_EXT    = 2'b11
  } src_stat_e;

  typedef enum logic {
    REQ_IDLE = 1'b0,
    REQ_HOLD = 1'b1
  } req_state_e;

endpackage

// File: rtl/mclk_sw_sync.sv
`timescale 1ns/1ps
// Flop chain used both as a synchroniser and as a clock-gate enable leg.
module mclk_sw_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0,
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (FALLING) begin : g_neg
      always_ff @(negedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end else begin : g_pos
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/mclk_sw_req.sv
`timescale 1ns/1ps
// Oscillator-domain request logic: flag sync, bus gating, hold-off timer.
module mclk_sw_req
  import mclk_sw_pkg::*;
#(
  parameter int HOLD_CYC    = 1800,
  parameter int SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic rst,
  input  logic ext_present,
  input  logic bus_active,
  input  logic bus_stop,
  output logic sel_ext,
  output logic hold_busy
);

  localparam int CNT_W = $clog2(HOLD_CYC + 1);

  logic             flag_s;
  logic             pending;
  logic             go;
  req_state_e       state;
  logic [CNT_W-1:0] cnt;

  mclk_sw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .FALLING(1'b0)) u_flag (
    .clk(osc_clk), .rst(rst), .d(ext_present), .q(flag_s)
  );

  // R2: a level mismatch stays pending until served (R9)
  assign pending = flag_s ^ sel_ext;
  // R3: start only with the bus idle or at its stop condition
  assign go = pending && (bus_stop || !bus_active);

  always_ff @(posedge osc_clk) begin
    if (rst) begin
      state     <= REQ_IDLE;
      sel_ext   <= 1'b0;
      hold_busy <= 1'b0;
      cnt       <= '0;
    end else begin
      case (state)
        REQ_IDLE: begin
          if (go) begin
            sel_ext   <= ~sel_ext;
            hold_busy <= 1'b1;
            cnt       <= CNT_W'(HOLD_CYC - 1);
            state     <= REQ_HOLD;
          end
        end
        REQ_HOLD: begin
          if (cnt == '0) begin
            hold_busy <= 1'b0;
            state     <= REQ_IDLE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= REQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mclk_sw_stat.sv
`timescale 1ns/1ps
// Status code register clocked by the selected (output) clock.
module mclk_sw_stat
  import mclk_sw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      mclk,
  input  logic      rst,
  input  logic      hold_busy,
  input  logic      ext_en,
  output src_stat_e src_stat
);

  logic      busy_m;
  src_stat_e target;

  mclk_sw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .FALLING(1'b0)) u_busy (
    .clk(mclk), .rst(rst), .d(hold_busy), .q(busy_m)
  );

  always_comb begin
    if (busy_m)      target = SRC_MOVING;
    else if (ext_en) target = SRC_EXT;
    else             target = SRC_OSC;
  end

  // R6: a two-bit jump is always routed through the transition code
  always_ff @(posedge mclk) begin
    if (rst)                           src_stat <= SRC_OSC;
    else if ((src_stat ^ target) == 2'b11) src_stat <= SRC_MOVING;
    else                               src_stat <= target;
  end

endmodule

// File: rtl/mclk_switch.sv
`timescale 1ns/1ps
module mclk_switch
  import mclk_sw_pkg::*;
#(
  parameter int unsigned OSC_FREQ_HZ = 12_000_000,
  parameter int unsigned HOLD_US     = 150,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       osc_clk,
  input  logic       ext_clk,
  input  logic       rst,
  input  logic       ext_present,
  input  logic       bus_active,
  input  logic       bus_stop,
  output logic       mclk,
  output logic       hold_busy,
  output logic [1:0] src_stat,
  output logic       osc_pd
);

  localparam longint unsigned HOLD_PROD = longint'(OSC_FREQ_HZ) * longint'(HOLD_US);
  localparam int HOLD_CYC = int'((HOLD_PROD + 64'd999_999) / 64'd1_000_000);

  logic      sel_ext;
  logic      osc_en;
  logic      ext_en;
  logic      flag_x;
  logic      busy_x;
  src_stat_e stat_w;

  mclk_sw_req #(.HOLD_CYC(HOLD_CYC), .SYNC_STAGES(SYNC_STAGES)) u_req (
    .osc_clk(osc_clk), .rst(rst), .ext_present(ext_present),
    .bus_active(bus_active), .bus_stop(bus_stop),
    .sel_ext(sel_ext), .hold_busy(hold_busy)
  );

  // R5: cross-coupled gate legs, each on its own source's falling edge
  mclk_sw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .FALLING(1'b1)) u_osc_leg (
    .clk(osc_clk), .rst(rst), .d(~sel_ext & ~ext_en), .q(osc_en)
  );

  mclk_sw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .FALLING(1'b1)) u_ext_leg (
    .clk(ext_clk), .rst(rst), .d(sel_ext & ~osc_en), .q(ext_en)
  );

  assign mclk = (osc_clk & osc_en) | (ext_clk & ext_en);

  mclk_sw_stat #(.SYNC_STAGES(SYNC_STAGES)) u_stat (
    .mclk(mclk), .rst(rst), .hold_busy(hold_busy), .ext_en(ext_en), .src_stat(stat_w)
  );

  assign src_stat = stat_w;

  // R8: power-down indication lives on the external clock, which runs
  // throughout a switch, so it can be withdrawn while the oscillator is off.
  mclk_sw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .FALLING(1'b0)) u_flag_x (
    .clk(ext_clk), .rst(rst), .d(ext_present), .q(flag_x)
  );

  mclk_sw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .FALLING(1'b0)) u_busy_x (
    .clk(ext_clk), .rst(rst), .d(hold_busy), .q(busy_x)
  );

  always_ff @(posedge ext_clk) begin
    if (rst || !flag_x)        osc_pd <= 1'b0;
    else if (ext_en && !busy_x) osc_pd <= 1'b1;
  end

endmodule

// File: rtl/mclk_switch_chk.sv
`timescale 1ns/1ps
module mclk_switch_chk (
  input logic       osc_clk,
  input logic       mclk,
  input logic       rst,
  input logic       bus_active,
  input logic       bus_stop,
  input logic       hold_busy,
  input logic       sel_ext,
  input logic       osc_en,
  input logic       ext_en,
  input logic       osc_pd,
  input logic [1:0] src_stat,
  input int         hold_cyc
);

  int busy_run;

  always_ff @(posedge osc_clk) begin
    if (rst)            busy_run <= 0;
    else if (hold_busy) busy_run <= busy_run + 1;
    else                busy_run <= 0;
  end

  AST_EN_EXCLUSIVE: assert property (@(posedge osc_clk) disable iff (rst) !(osc_en && ext_en)); // R5
  AST_START_GATED: assert property (@(posedge osc_clk) disable iff (rst) $rose(hold_busy) |-> ($past(bus_stop) || !$past(bus_active))); // R3
  AST_HOLD_LENGTH: assert property (@(posedge osc_clk) disable iff (rst) $fell(hold_busy) |-> (busy_run == hold_cyc)); // R4
  AST_SEL_ON_START: assert property (@(posedge osc_clk) disable iff (rst) !$stable(sel_ext) |-> $rose(hold_busy)); // R2
  AST_SEL_FROZEN: assert property (@(posedge osc_clk) disable iff (rst) hold_busy |=> $stable(sel_ext)); // R9
  AST_PD_ONLY_EXT: assert property (@(posedge osc_clk) disable iff (rst) osc_pd |-> !osc_en); // R8
  AST_STAT_LEGAL: assert property (@(posedge mclk) disable iff (rst) src_stat != 2'b10); // R6
  AST_STAT_ONE_BIT: assert property (@(posedge mclk) disable iff (rst) $countones(src_stat ^ $past(src_stat)) <= 1); // R6

endmodule

bind mclk_switch mclk_switch_chk u_chk (
  .osc_clk(osc_clk), .mclk(mclk), .rst(rst), .bus_active(bus_active),
  .bus_stop(bus_stop), .hold_busy(hold_busy), .sel_ext(sel_ext),
  .osc_en(osc_en), .ext_en(ext_en), .osc_pd(osc_pd), .src_stat(src_stat),
  .hold_cyc(HOLD_CYC)
);

// File: tb/sim_mclk_switch.sv
`timescale 1ns/1ps
module sim_mclk_switch;

  localparam int OSC_HZ  = 125_000_000;
  localparam int HOLD_US = 4;
  localparam int HOLD    = 500; // ceil(125e6 * 4 / 1e6)

  logic osc_clk = 1'b0;
  logic ext_clk = 1'b0;
  logic rst = 1'b1;
  logic ext_present = 1'b0;
  logic bus_active = 1'b0;
  logic bus_stop = 1'b0;
  logic mclk, hold_busy, osc_pd;
  logic [1:0] src_stat;

  always #4 osc_clk = ~osc_clk;
  always #5.5 ext_clk = ~ext_clk;

  mclk_switch #(.OSC_FREQ_HZ(OSC_HZ), .HOLD_US(HOLD_US)) u0 (
    .osc_clk(osc_clk), .ext_clk(ext_clk), .rst(rst), .ext_present(ext_present),
    .bus_active(bus_active), .bus_stop(bus_stop), .mclk(mclk),
    .hold_busy(hold_busy), .src_stat(src_stat), .osc_pd(osc_pd)
  );

  int  vectors = 0;
  int  errs = 0;
  bit  done = 0;

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference for the hold-off output (R2, R3, R4, R9)
  int m_s1 = 0, m_s2 = 0, m_cnt = 0;
  bit m_sel = 0, m_busy = 0;

  always @(posedge osc_clk) begin
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_sel = 0; m_busy = 0; m_cnt = 0;
    end else begin
      bit want;
      want = (m_s2 != int'(m_sel));
      m_s2 = m_s1;
      m_s1 = int'(ext_present);
      if (m_busy) begin
        if (m_cnt == 0) m_busy = 0;
        else m_cnt--;
      end else if (want && (bus_stop || !bus_active)) begin
        m_sel = !m_sel;
        m_busy = 1;
        m_cnt = HOLD - 1;
      end
    end
  end

  always @(negedge osc_clk) begin
    if (!rst && !done) chk("R4 hold_busy vs model", int'(hold_busy), int'(m_busy));
  end

  task automatic cyc(int n);
    repeat (n) @(negedge osc_clk);
  endtask

  task automatic wait_busy(bit v);
    while (hold_busy != v) @(negedge osc_clk);
  endtask

  task automatic chk_period(string tag, int exp_tenths);
    realtime t0;
    @(posedge mclk);
    t0 = $realtime;
    @(posedge mclk);
    chk(tag, int'(($realtime - t0) * 10.0), exp_tenths);
    @(negedge osc_clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
  endtask

  initial begin
    repeat (200000) @(posedge osc_clk);
    if (!done) begin
      done = 1;
      vectors++;
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(10);
    chk("R1 src_stat in reset", int'(src_stat), 0);
    rst = 1'b0;
    cyc(10);
    chk("R1 hold_busy after reset", int'(hold_busy), 0);
    chk("R1 src_stat after reset", int'(src_stat), 0);
    chk("R1 osc_pd after reset", int'(osc_pd), 0);
    chk_period("R1 mclk period osc", 80);

    // stop pulses with nothing pending: no effect
    bus_active = 1'b1;
    cyc(3); bus_stop = 1'b1; cyc(1); bus_stop = 1'b0;
    cyc(3); bus_stop = 1'b1; cyc(1); bus_stop = 1'b0; bus_active = 1'b0;
    cyc(10);
    chk("R3 idle stop ignored busy", int'(hold_busy), 0);
    chk("R3 idle stop ignored stat", int'(src_stat), 0);

    // switch to external with bus idle
    ext_present = 1'b1;
    wait_busy(1);
    cyc(HOLD / 2);
    chk("R7 stat mid hold to ext", int'(src_stat), 1);
    chk("R8 osc_pd held during hold", int'(osc_pd), 0);
    wait_busy(0);
    cyc(30);
    chk("R6 stat on ext", int'(src_stat), 3);
    chk("R8 osc_pd on ext", int'(osc_pd), 1);
    chk_period("R10 mclk period ext", 110);

    // switch back, deferred by an open transaction
    bus_active = 1'b1;
    ext_present = 1'b0;
    cyc(100);
    chk("R3 no start while bus open", int'(hold_busy), 0);
    chk("R3 stat unchanged while bus open", int'(src_stat), 3);
    chk("R8 osc_pd cleared on flag drop", int'(osc_pd), 0);
    bus_stop = 1'b1; cyc(1); bus_stop = 1'b0; bus_active = 1'b0;
    chk("R3 start at stop", int'(hold_busy), 1);
    cyc(HOLD / 2);
    chk("R7 stat mid hold to osc", int'(src_stat), 1);
    wait_busy(0);
    cyc(30);
    chk("R6 stat back on osc", int'(src_stat), 0);
    chk("R8 osc_pd after return", int'(osc_pd), 0);
    chk_period("R10 mclk period osc again", 80);

    // flag flips during a switch: queued until hold-off ends
    ext_present = 1'b1;
    wait_busy(1);
    cyc(50);
    ext_present = 1'b0;
    wait_busy(0);
    cyc(5);
    chk("R9 queued switch started", int'(hold_busy), 1);
    wait_busy(0);
    cyc(30);
    chk("R9 final stat osc", int'(src_stat), 0);
    chk("R9 osc_pd stays low", int'(osc_pd), 0);
    chk_period("R10 mclk period after queued", 80);
    chk("R2 no further switch", int'(hold_busy), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule